// File: doc/BRIEF.md
# Four-Channel DMA Request Controller

This block lets four peripherals move blocks of data to or from memory without the CPU touching each word. While the CPU owns the bus, it programs the block through a small register window. It writes a start address and a transfer count for each channel, plus one mode register. When an enabled peripheral raises its request, the controller asks the CPU for the bus with a hold request. It waits for hold-acknowledge, then runs one transfer per grant. Each transfer drives the granted channel's current address, a memory read or write strobe, and that channel's acknowledge, and flags terminal count on the last word of a block.

Requests are asynchronous and pass through a synchronizer. Arbitration is repeated before every transfer, so a higher-priority request cuts into a running burst of a lower one. Priority is fixed (channel 0 first) or rotating. Terminal count is logged in a status register that clears when it is read. A channel can be made to switch itself off at terminal count. Channel 2 can instead reload itself from channel 3's registers and start the next block without CPU help.

The sequencer has four states. S_IDLE moves to S_HOLD when any enabled synchronized request is pending. S_HOLD returns to S_IDLE if the requests vanish, and moves to S_XFER when hold-acknowledge is sampled high, latching the arbiter's winner. S_XFER lasts one cycle and always moves to S_GAP. S_GAP waits as many cycles as the synchronizer is deep, so that a request dropped on acknowledge is seen as dropped. It then moves to S_XFER (request pending, bus still granted), S_HOLD (request pending, bus withdrawn) or S_IDLE (nothing pending).

Top module: `dma4_ctrl`

## Requirements
- R1: CPU register window: select codes 0..7 address a channel register, with channel = sel[2:1] and sel[0]=0 for the address register or 1 for the count register. Code 8 is the mode register and code 9 is the status register. A write needs cpu_cs and cpu_wr, and is ignored while hlda is high. cpu_rdata shows the selected register combinationally.
- R2: After reset all registers read zero, hrq is low and dack is zero.
- R3: hrq rises only after an enabled request has been synchronized. A request on a channel whose mode enable bit (mode[3:0]) is clear never raises hrq. hrq falls once no enabled request is pending.
- R4: A transfer only happens in a cycle after hlda was sampled high. Each transfer lasts one cycle with exactly one dack bit set, that of the granted channel.
- R5: A transfer drives mem_addr with the channel's current address, and the address register then increments, wrapping at the address width.
- R6: tc is high during the transfer made while the channel's count is zero. The count decrements after every transfer and wraps from zero to all ones. A count of N-1 gives N transfers to terminal count.
- R7: Mode bit 7 picks the direction: 1 pulses mem_wr during each transfer, 0 pulses mem_rd.
- R8: Status bits 3:0 set when the matching channel reaches terminal count, and clear when the status register is read. Bit 4 is the update flag. Writes to the status register have no effect.
- R9: With mode bit 4 clear, the lowest-numbered pending channel wins each arbitration. Because arbitration is redone before every transfer, a higher request preempts a running burst.
- R10: With mode bit 4 set, priority rotates: the channel served last becomes lowest. Channel 0 ranks first after reset.
- R11: With mode bit 5 set, a channel reaching terminal count has its enable bit cleared and makes no more transfers.
- R12: With mode bit 6 set, channel 2 reaching terminal count reloads its address and count from channel 3's registers and stays enabled. The update flag is set at that reload and cleared at the end of channel 2's next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_cs | input | 1 | Register window select |
| cpu_rd | input | 1 | Register read strobe (status read clears flags) |
| cpu_wr | input | 1 | Register write strobe |
| cpu_sel | input | 4 | Register select code |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data of the selected register |
| dreq | input | 4 | Asynchronous per-channel requests |
| dack | output | 4 | Per-channel transfer acknowledge |
| hrq | output | 1 | Bus hold request to the CPU |
| hlda | input | 1 | Hold acknowledge from the CPU |
| mem_addr | output | ADDR_W | Transfer address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| tc | output | 1 | Terminal count of the current transfer |

## Verification
The hardest case to reach from the ports is a preemption that lands in the middle of a burst. The higher request must arrive while a lower channel is mid-block, and the synchronizer latency plus the S_GAP window fix exactly which transfer it displaces. The bench's peripheral model raises channel 0's request at the moment it sees channel 3's third acknowledge, and requires channel 0's two words to be the fourth and fifth entries in the transfer log. The channel-2 reload chain is the other deep case. It is reached by letting one request stream run across two terminal counts, then reading the status register to find the update flag still set, and clearing it with a single further transfer.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int NCH  = 4;
    localparam int CH_W = 2;
    typedef logic [CH_W-1:0] ch_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HOLD,
        S_XFER,
        S_GAP
    } dma_state_e;

    localparam int MODE_ROT  = 4;
    localparam int MODE_STOP = 5;
    localparam int MODE_AUTO = 6;
    localparam int MODE_DIR  = 7;

    localparam logic [3:0] SEL_MODE = 4'd8;
    localparam logic [3:0] SEL_STAT = 4'd9;

    localparam ch_t AL_DST = ch_t'(2);
    localparam ch_t AL_SRC = ch_t'(3);
endpackage

// File: rtl/dma4_sync.sv
module dma4_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb
    import dma4_pkg::*;
(
    input  logic [NCH-1:0] req,
    input  logic           rotate,
    input  ch_t            last,
    output logic           valid,
    output ch_t            idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int k = 0; k < NCH; k++) begin
            int c;
            c = rotate ? ((int'(last) + 1 + k) % NCH) : k;
            if (!valid && req[c]) begin
                valid = 1'b1;
                idx   = ch_t'(c);
            end
        end
    end
endmodule

// File: rtl/dma4_regfile.sv
module dma4_regfile
    import dma4_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 14,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [3:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              done,
    input  ch_t               xfer_ch,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              xfer_last,
    output logic [7:0]        mode
);
    logic [ADDR_W-1:0] addr_q [NCH];
    logic [CNT_W-1:0]  cnt_q  [NCH];
    logic [NCH-1:0]    tcf_q;
    logic              upd_q;
    logic              reload_now;
    ch_t               sel_ch;

    assign sel_ch     = sel[CH_W:1];
    assign xfer_addr  = addr_q[xfer_ch];
    assign xfer_last  = (cnt_q[xfer_ch] == '0);
    assign reload_now = done && xfer_last && mode[MODE_AUTO] && (xfer_ch == AL_DST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                addr_q[i] <= '0;
                cnt_q[i]  <= '0;
            end
            mode  <= '0;
            tcf_q <= '0;
            upd_q <= 1'b0;
        end else begin
            if (wr_en) begin
                if (!sel[3]) begin
                    if (sel[0]) cnt_q[sel_ch]  <= wdata[CNT_W-1:0];
                    else        addr_q[sel_ch] <= wdata[ADDR_W-1:0];
                end else if (sel == SEL_MODE) begin
                    mode <= wdata[7:0];
                end
            end
            if (rd_en && sel == SEL_STAT) tcf_q <= '0;
            if (done) begin
                addr_q[xfer_ch] <= addr_q[xfer_ch] + 1'b1;
                cnt_q[xfer_ch]  <= cnt_q[xfer_ch] - 1'b1;
                if (xfer_ch == AL_DST) upd_q <= 1'b0;
                if (xfer_last) begin
                    tcf_q[xfer_ch] <= 1'b1;
                    if (reload_now) begin
                        addr_q[AL_DST] <= addr_q[AL_SRC];
                        cnt_q[AL_DST]  <= cnt_q[AL_SRC];
                        upd_q          <= 1'b1;
                    end else if (mode[MODE_STOP]) begin
                        mode[xfer_ch] <= 1'b0;
                    end
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (!sel[3]) begin
            if (sel[0]) rdata = DATA_W'(cnt_q[sel_ch]);
            else        rdata = DATA_W'(addr_q[sel_ch]);
        end else if (sel == SEL_MODE) begin
            rdata = DATA_W'(mode);
        end else if (sel == SEL_STAT) begin
            rdata = DATA_W'({3'b000, upd_q, tcf_q});
        end
    end

    // R5
    addr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !reload_now) |=> addr_q[$past(xfer_ch)] == ADDR_W'($past(xfer_addr) + 1'b1));

    // R12
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_now |=> (upd_q && addr_q[AL_DST] == $past(addr_q[AL_SRC]) && mode[AL_DST]));

    // R11
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && xfer_last && mode[MODE_STOP] && !reload_now) |=> !mode[$past(xfer_ch)]);

    // R8
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_STAT && !done) |=> tcf_q == '0);

    for (genvar g = 0; g < NCH; g++) begin : g_tcf
        // R8
        tc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tcf_q[g]) |-> $past(done && xfer_last && xfer_ch == ch_t'(g)));
    end
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 14,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_cs,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [3:0]        cpu_sel,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [NCH-1:0]    dreq,
    output logic [NCH-1:0]    dack,
    output logic              hrq,
    input  logic              hlda,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              tc
);
    localparam int GAP_W = $clog2(SYNC_STAGES + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(SYNC_STAGES - 1);

    dma_state_e        state_q, state_d;
    ch_t               gnt_q, last_q, arb_idx;
    logic              arb_valid;
    logic [GAP_W-1:0]  gap_q;
    logic [NCH-1:0]    req_sync, pending;
    logic [7:0]        mode;
    logic [ADDR_W-1:0] xfer_addr;
    logic              xfer_last, done, wr_en, rd_en;

    assign wr_en   = cpu_cs && cpu_wr && !hlda;
    assign rd_en   = cpu_cs && cpu_rd && !hlda;
    assign pending = req_sync & mode[NCH-1:0];
    assign done    = (state_q == S_XFER);

    dma4_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(dreq), .q(req_sync)
    );

    dma4_arb u_arb (
        .req(pending), .rotate(mode[MODE_ROT]), .last(last_q),
        .valid(arb_valid), .idx(arb_idx)
    );

    dma4_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .sel(cpu_sel), .wdata(cpu_wdata), .rdata(cpu_rdata),
        .done(done), .xfer_ch(gnt_q), .xfer_addr(xfer_addr),
        .xfer_last(xfer_last), .mode(mode)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (|pending) state_d = S_HOLD;
            S_HOLD: begin
                if (!(|pending))            state_d = S_IDLE;
                else if (hlda && arb_valid) state_d = S_XFER;
            end
            S_XFER: state_d = S_GAP;
            S_GAP: begin
                if (gap_q == GAP_LAST) begin
                    if (!(|pending)) state_d = S_IDLE;
                    else if (hlda)   state_d = S_XFER;
                    else             state_d = S_HOLD;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            gnt_q   <= '0;
            last_q  <= ch_t'(NCH - 1);
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == S_XFER) gnt_q <= arb_idx;
            if (state_q == S_XFER) begin
                last_q <= gnt_q;
                gap_q  <= '0;
            end else if (state_q == S_GAP) begin
                gap_q  <= gap_q + 1'b1;
            end
        end
    end

    always_comb begin
        hrq      = (state_q != S_IDLE);
        dack     = '0;
        mem_addr = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        tc       = 1'b0;
        if (state_q == S_XFER) begin
            dack[gnt_q] = 1'b1;
            mem_addr    = xfer_addr;
            mem_rd      = !mode[MODE_DIR];
            mem_wr      = mode[MODE_DIR];
            tc          = xfer_last;
        end
    end

    // R4
    dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    // R4
    xfer_needs_hlda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack) |-> $past(hlda));

    // R3
    hrq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hrq) |-> $past(pending == '0));

    // R9
    fixed_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dack) && !$past(mode[MODE_ROT])) |-> (($past(pending) & (dack - 1'b1)) == '0));
endmodule

// File: tb/dma4_ctrl_tb.sv
module dma4_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 14;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              cpu_cs = 0, cpu_rd = 0, cpu_wr = 0;
    logic [3:0]        cpu_sel = 0;
    logic [DATA_W-1:0] cpu_wdata = 0, cpu_rdata;
    logic [3:0]        dreq, dack;
    logic              hrq, hlda = 0, mem_rd, mem_wr, tc;
    logic [ADDR_W-1:0] mem_addr;

    dma4_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dreq(dreq), .dack(dack), .hrq(hrq), .hlda(hlda),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .tc(tc)
    );

    int checks = 0, failures = 0;
    int rem [4] = '{0, 0, 0, 0};
    int log_n = 0, mon_ch, hd = 0, preempt_arm = 0;
    int log_ch [64];
    int log_addr [64];
    int log_tc [64];
    int log_wr [64];
    int log_rd [64];
    int base, n, exp_ch, exp_addr, exp_tc;
    logic [DATA_W-1:0] rv;

    always_comb for (int i = 0; i < 4; i++) dreq[i] = (rem[i] != 0);

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // peripheral model and transfer log
    always @(negedge clk) begin
        if (rst_n && dack != 0) begin
            chk("R4", "dack one-hot", $countones(dack), 1);
            chk("R4", "hlda during transfer", hlda, 1);
            mon_ch = 0;
            for (int i = 0; i < 4; i++) if (dack[i]) mon_ch = i;
            if (log_n < 64) begin
                log_ch[log_n]   = mon_ch;
                log_addr[log_n] = int'(mem_addr);
                log_tc[log_n]   = int'(tc);
                log_wr[log_n]   = int'(mem_wr);
                log_rd[log_n]   = int'(mem_rd);
            end
            log_n++;
            if (rem[mon_ch] > 0) rem[mon_ch]--;
            if (preempt_arm != 0 && log_n == 3) begin
                rem[0] = 2;
                preempt_arm = 0;
            end
        end
    end

    // CPU hold-acknowledge model: grants two cycles after the request
    always @(negedge clk) begin
        if (!rst_n || !hrq) begin
            hlda = 1'b0;
            hd = 0;
        end else if (hd < 2) begin
            hd++;
        end else begin
            hlda = 1'b1;
        end
    end

    function automatic logic [3:0] rsel(input int ch, input int is_cnt);
        return {1'b0, 2'(ch), 1'(is_cnt)};
    endfunction

    task automatic cpu_write(input logic [3:0] s, input int d);
        @(negedge clk);
        cpu_cs = 1; cpu_wr = 1; cpu_sel = s; cpu_wdata = DATA_W'(d);
        @(negedge clk);
        cpu_cs = 0; cpu_wr = 0;
    endtask

    task automatic cpu_read(input logic [3:0] s, output logic [DATA_W-1:0] d);
        @(negedge clk);
        cpu_cs = 1; cpu_rd = 1; cpu_sel = s;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_cs = 0; cpu_rd = 0;
    endtask

    task automatic wait_done();
        int quiet;
        quiet = 0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 5000 && quiet < 4; i++) begin
            @(negedge clk);
            if (!hrq) quiet++; else quiet = 0;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        chk("R2", "hrq after reset", hrq, 0);
        chk("R2", "dack after reset", dack, 0);
        cpu_read(4'd9, rv); chk("R2", "status after reset", rv, 0);
        cpu_read(4'd8, rv); chk("R2", "mode after reset", rv, 0);
        cpu_read(rsel(0, 0), rv); chk("R2", "ch0 address after reset", rv, 0);

        // R1 register window sweep
        for (int c = 0; c < 4; c++) begin
            cpu_write(rsel(c, 0), 'hA000 + c * 'h0101);
            cpu_write(rsel(c, 1), 'h1234 + c * 'h0111);
        end
        for (int c = 0; c < 4; c++) begin
            cpu_read(rsel(c, 0), rv); chk("R1", "address readback", rv, 'hA000 + c * 'h0101);
            cpu_read(rsel(c, 1), rv); chk("R1", "count readback", rv, 'h1234 + c * 'h0111);
        end
        cpu_write(4'd8, 'hF0);
        cpu_read(4'd8, rv); chk("R1", "mode readback", rv, 'hF0);
        cpu_write(4'd8, 0);
        cpu_write(4'd9, 'hFF);
        cpu_read(4'd9, rv); chk("R8", "status write ignored", rv, 0);

        // R5 R6 R7 single-channel blocks on every channel
        for (int k = 0; k < 4; k++) begin
            n = k + 2;
            base = 'h00FE + 'h1100 * k;
            cpu_write(rsel(k, 0), base);
            cpu_write(rsel(k, 1), n - 1);
            cpu_write(4'd8, ((k % 2) << 7) | (1 << k));
            log_n = 0;
            rem[k] = n;
            wait_done();
            chk("R6", "transfers in block", log_n, n);
            for (int i = 0; i < n; i++) begin
                chk("R4", "granted channel", log_ch[i], k);
                chk("R5", "sequential address", log_addr[i], (base + i) & 'hFFFF);
                chk("R6", "tc on last word", log_tc[i], (i == n - 1) ? 1 : 0);
                chk("R7", "write strobe", log_wr[i], k % 2);
                chk("R7", "read strobe", log_rd[i], 1 - (k % 2));
            end
            cpu_read(4'd9, rv); chk("R8", "status tc bit", rv, 1 << k);
            cpu_read(4'd9, rv); chk("R8", "status cleared by read", rv, 0);
            cpu_read(rsel(k, 0), rv); chk("R5", "address after block", rv, (base + n) & 'hFFFF);
            cpu_read(rsel(k, 1), rv); chk("R6", "count wrapped", rv, (1 << CNT_W) - 1);
            chk("R3", "hrq released", hrq, 0);
        end

        // R3 disabled channel raises no hold request
        cpu_write(4'd8, 'h0D);
        log_n = 0;
        rem[1] = 3;
        repeat (20) @(negedge clk);
        chk("R3", "hrq for disabled channel", hrq, 0);
        chk("R3", "no transfers for disabled channel", log_n, 0);
        rem[1] = 0;
        repeat (4) @(negedge clk);

        // R9 fixed priority
        for (int c = 0; c < 4; c++) begin
            cpu_write(rsel(c, 0), 'h2000 + c * 'h100);
            cpu_write(rsel(c, 1), 1);
        end
        cpu_write(4'd8, 'h0F);
        log_n = 0;
        for (int c = 0; c < 4; c++) rem[c] = 2;
        wait_done();
        chk("R9", "fixed transfers", log_n, 8);
        for (int i = 0; i < 8; i++) begin
            chk("R9", "fixed order channel", log_ch[i], i / 2);
            chk("R9", "fixed order address", log_addr[i], 'h2000 + (i / 2) * 'h100 + i % 2);
        end
        cpu_read(4'd9, rv); chk("R8", "all tc bits", rv, 'h0F);

        // R10 rotating priority
        for (int c = 0; c < 4; c++) begin
            cpu_write(rsel(c, 0), 'h3000 + c * 'h100);
            cpu_write(rsel(c, 1), 1);
        end
        cpu_write(4'd8, 'h1F);
        log_n = 0;
        for (int c = 0; c < 4; c++) rem[c] = 2;
        wait_done();
        chk("R10", "rotating transfers", log_n, 8);
        for (int i = 0; i < 8; i++) begin
            chk("R10", "rotating order channel", log_ch[i], i % 4);
            chk("R10", "rotating address", log_addr[i], 'h3000 + (i % 4) * 'h100 + i / 4);
            chk("R10", "rotating tc", log_tc[i], (i >= 4) ? 1 : 0);
        end
        cpu_read(4'd9, rv);

        // R9 preemption of a burst, R1 write ignored under hold
        cpu_write(rsel(3, 0), 'h5000); cpu_write(rsel(3, 1), 9);
        cpu_write(rsel(0, 0), 'h5800); cpu_write(rsel(0, 1), 1);
        cpu_write(4'd8, 'h0F);
        log_n = 0;
        preempt_arm = 1;
        rem[3] = 10;
        wait (hlda == 1'b1);
        cpu_write(rsel(1, 0), 'hDEAD);
        wait_done();
        chk("R9", "preempt transfers", log_n, 12);
        for (int i = 0; i < 12; i++) begin
            if (i == 3 || i == 4) begin
                exp_ch = 0; exp_addr = 'h5800 + i - 3; exp_tc = (i == 4) ? 1 : 0;
            end else begin
                exp_ch = 3;
                exp_addr = 'h5000 + ((i < 3) ? i : i - 2);
                exp_tc = (i == 11) ? 1 : 0;
            end
            chk("R9", "preempt channel", log_ch[i], exp_ch);
            chk("R9", "preempt address", log_addr[i], exp_addr);
            chk("R6", "preempt tc", log_tc[i], exp_tc);
        end
        cpu_read(rsel(1, 0), rv); chk("R1", "write under hold ignored", rv, 'h3102);
        cpu_read(4'd9, rv); chk("R8", "preempt tc bits", rv, 'h09);

        // R11 stop on terminal count
        cpu_write(rsel(0, 0), 'h0200); cpu_write(rsel(0, 1), 1);
        cpu_write(4'd8, 'h21);
        log_n = 0;
        rem[0] = 5;
        wait_done();
        chk("R11", "transfers before stop", log_n, 2);
        cpu_read(4'd8, rv); chk("R11", "enable cleared", rv, 'h20);
        chk("R11", "hrq after stop", hrq, 0);
        rem[0] = 0;
        cpu_read(4'd9, rv);

        // R12 channel-2 autoload
        cpu_write(rsel(2, 0), 'h0300); cpu_write(rsel(2, 1), 1);
        cpu_write(rsel(3, 0), 'h0400); cpu_write(rsel(3, 1), 2);
        cpu_write(4'd8, 'h44);
        log_n = 0;
        rem[2] = 5;
        wait_done();
        chk("R12", "autoload transfers", log_n, 5);
        for (int i = 0; i < 5; i++) begin
            exp_addr = (i < 2) ? 'h0300 + i : 'h0400 + i - 2;
            chk("R12", "autoload address", log_addr[i], exp_addr);
            chk("R12", "autoload tc", log_tc[i], (i == 1 || i == 4) ? 1 : 0);
        end
        cpu_read(4'd9, rv); chk("R12", "update flag and tc", rv, 'h14);
        log_n = 0;
        rem[2] = 1;
        wait_done();
        chk("R12", "restart transfer", log_n, 1);
        chk("R12", "restart address", log_addr[0], 'h0400);
        cpu_read(4'd9, rv); chk("R12", "update flag cleared", rv, 'h00);
        cpu_read(rsel(2, 1), rv); chk("R12", "ch2 count after restart", rv, 1);
        cpu_read(rsel(3, 0), rv); chk("R12", "ch3 address untouched", rv, 'h0400);
        cpu_read(4'd8, rv); chk("R12", "ch2 still enabled", rv, 'h44);

        summary();
        $finish;
    end
endmodule